// File: doc/BRIEF.md
# Ping-pong card data buffer

This block sits between a 32-bit host data register port and a 32-bit card-side data engine. It holds block data in a word-addressed store of two equal portions. A direction input decides which side produces the data and which side consumes it. When the direction input is 1 (read), the card side writes words in and the host reads them out. When it is 0 (write), the host writes and the card side reads.

For short blocks, meaning a byte length no larger than one portion, the store runs as a ping-pong pair. The producer fills one portion while the consumer empties the other, and the two portions alternate. For longer blocks the whole store is treated as one portion, so only one side may move data at a time. A same-cycle request from both sides in that mode raises a bad-access flag.

The host sees sticky ready flags, cleared by writing 1 to them, and live enable levels. On the card side it sees a pair of handshake levels that stand in for the clock-domain crossing. Both sides run on a single clock.

Top module: `card_pingpong_buf`

## Requirements
- R1: While reset is asserted, `irq_flags` is zero, `card_out_valid` is 0, `card_in_ready` equals `cfg_dir_rd`, and `buf_status` is zero except bit 10, which equals the inverse of `cfg_dir_rd`.
- R2: With `cfg_dir_rd`=1 only `card_wr_valid` writes and only `host_rd_req` reads. With `cfg_dir_rd`=0 only `host_wr_valid` writes and only `card_rd_req` reads. Strobes on the other two inputs change no state.
- R3: The consumer receives every word of every block in the order the producer wrote it.
- R4: With a block length of at most one portion in bytes, the producer may complete two blocks before the consumer reads anything. The producer-ready level (`card_in_ready` in read, `buf_status[10]` in write) stays 1 after the first block and drops to 0 after the second.
- R5: The consumer cannot take a word from a portion until the last word of that block has been written. A read while the consumer level (`buf_status[11]` in read, `card_out_valid` in write) is 0 returns zero and does not advance the read position.
- R6: With a block length larger than one portion in bytes, the whole store is one portion. After a block completes, the producer-ready level stays 0 until the consumer has read the entire block.
- R7: In single-portion mode, a producer request and a consumer request in the same cycle set `irq_flags[29]` at that clock edge. In ping-pong mode bit 29 is never set.
- R8: `irq_flags[5]` is set one cycle after a complete block becomes readable by the host in read direction. This includes the case where the host finishes one portion while the other is already full.
- R9: `irq_flags[4]` is set one cycle after a free portion becomes writable by the host in write direction, including right after reset.
- R10: `buf_status[11]` is 1 exactly while the direction is read and the portion at the host read position is full. `buf_status[10]` is 1 exactly while the direction is write and the portion at the host write position is not full.
- R11: The block size in words is the byte length divided by 4 and rounded up. A length of 0 counts as one word, and the size is capped at the full store.
- R12: Writing 1 to an `irq_clr` bit clears that `irq_flags` bit unless a new event sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_rd | input | 1 | 1 = card to host, 0 = host to card |
| cfg_blk_len | input | LEN_W | Block length in bytes |
| host_wr_valid | input | 1 | Host writes one word to the data register |
| host_wr_data | input | DATA_W | Host write word |
| host_rd_req | input | 1 | Host reads one word from the data register |
| host_rd_data | output | DATA_W | Host read word, zero when not readable |
| card_wr_valid | input | 1 | Card engine delivers one word |
| card_wr_data | input | DATA_W | Card delivered word |
| card_in_ready | output | 1 | Card engine may deliver a word |
| card_rd_req | input | 1 | Card engine takes one word |
| card_rd_data | output | DATA_W | Word offered to the card engine |
| card_out_valid | output | 1 | A word is available to the card engine |
| irq_clr | input | 32 | Write-1-to-clear mask for irq_flags |
| irq_flags | output | 32 | Sticky flags: bit 29 bad access, bit 5 read ready, bit 4 write ready |
| buf_status | output | 32 | Levels: bit 11 read enable, bit 10 write enable |

## Verification
A wrong full flag or a stray read position shows at the ports within one cycle. It appears as a ready or enable level with the wrong value, or as a consumer word that does not match the producer's pattern for that block and index. A missed or doubled ready event shows as a sticky bit that is wrong two clock edges after a block boundary. A bad-access rule applied in the wrong mode flips bit 29 at the very edge of the simultaneous request. Every block length from 0 past the capped size is swept in both directions on a small store, so an off-by-one in rounding or in the mode threshold shows up as a level that changes one word early or late.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

  localparam int IRQ_BAD_BIT  = 29;
  localparam int IRQ_RRDY_BIT = 5;
  localparam int IRQ_WRDY_BIT = 4;
  localparam int ST_REN_BIT   = 11;
  localparam int ST_WEN_BIT   = 10;

  // words in one block: bytes rounded up to whole words, at least one, capped
  function automatic int unsigned words_for_len(int unsigned len_bytes,
                                                int unsigned bytes_per_word,
                                                int unsigned total_words);
    int unsigned w;
    w = (len_bytes + bytes_per_word - 1) / bytes_per_word;
    if (w == 0) w = 1;
    if (w > total_words) w = total_words;
    return w;
  endfunction

  // a block longer than one portion uses the whole store as one portion
  function automatic logic is_single(int unsigned len_bytes, int unsigned portion_bytes);
    return len_bytes > portion_bytes;
  endfunction

endpackage

// File: rtl/cpb_ram.sv
module cpb_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cpb_walker.sv
// Walks one side's position through a block; the portion alternates in
// ping-pong mode and stays at portion 0 in single-portion mode.
module cpb_walker #(
  parameter int PORTION_WORDS = 128,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              single,
  input  logic [ADDR_W-1:0] last_off,
  output logic              half,
  output logic              done,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] off_q;
  logic              half_q;

  assign done = step && (off_q == last_off);
  assign half = half_q;
  assign addr = off_q + (half_q ? ADDR_W'(PORTION_WORDS) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      half_q <= 1'b0;
    end else if (step) begin
      if (done) begin
        off_q  <= '0;
        half_q <= single ? 1'b0 : ~half_q;
      end else begin
        off_q  <= off_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cpb_irq_stat.sv
module cpb_irq_stat
  import cpb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir_rd,
  input  logic        single,
  input  logic        prod_full,
  input  logic        cons_full,
  input  logic        prod_req,
  input  logic        cons_req,
  input  logic        prod_done,
  input  logic        cons_done,
  input  logic [31:0] irq_clr,
  output logic [31:0] irq_flags,
  output logic [31:0] buf_status,
  output logic        ren,
  output logic        wen,
  output logic        bad_evt,
  output logic        rrdy_evt,
  output logic        wrdy_evt
);

  logic        ren_d, wen_d, prod_done_d, cons_done_d;
  logic [31:0] irq_q, set_vec;

  assign ren = dir_rd && cons_full;
  assign wen = !dir_rd && !prod_full;

  // a new block is offered when the level rises or the position moved on
  assign rrdy_evt = ren && (!ren_d || cons_done_d);
  assign wrdy_evt = wen && (!wen_d || prod_done_d);
  assign bad_evt  = single && prod_req && cons_req;

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_BAD_BIT]  = bad_evt;
    set_vec[IRQ_RRDY_BIT] = rrdy_evt;
    set_vec[IRQ_WRDY_BIT] = wrdy_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q       <= '0;
      ren_d       <= 1'b0;
      wen_d       <= 1'b0;
      prod_done_d <= 1'b0;
      cons_done_d <= 1'b0;
    end else begin
      irq_q       <= (irq_q & ~irq_clr) | set_vec;
      ren_d       <= ren;
      wen_d       <= wen;
      prod_done_d <= prod_done;
      cons_done_d <= cons_done;
    end
  end

  always_comb begin
    buf_status = '0;
    buf_status[ST_REN_BIT] = ren;
    buf_status[ST_WEN_BIT] = wen;
  end

  assign irq_flags = irq_q;

endmodule

// File: rtl/card_pingpong_buf.sv
module card_pingpong_buf
  import cpb_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int PORTION_WORDS = 128,
  parameter int LEN_W         = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir_rd,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic              host_wr_valid,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_req,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic              card_wr_valid,
  input  logic [DATA_W-1:0] card_wr_data,
  output logic              card_in_ready,
  input  logic              card_rd_req,
  output logic [DATA_W-1:0] card_rd_data,
  output logic              card_out_valid,
  input  logic [31:0]       irq_clr,
  output logic [31:0]       irq_flags,
  output logic [31:0]       buf_status
);

  localparam int NUM_PORTIONS  = 2;
  localparam int TOTAL_WORDS   = NUM_PORTIONS * PORTION_WORDS;
  localparam int ADDR_W        = $clog2(TOTAL_WORDS);
  localparam int BYTES_PW      = DATA_W / 8;
  localparam int PORTION_BYTES = PORTION_WORDS * BYTES_PW;

  // configuration decode
  logic [ADDR_W:0]   blk_words;
  logic [ADDR_W-1:0] last_off;
  logic              single_mode;

  assign blk_words   = (ADDR_W+1)'(words_for_len(32'(cfg_blk_len), BYTES_PW, TOTAL_WORDS));
  assign last_off    = ADDR_W'(blk_words - 1'b1);
  assign single_mode = is_single(32'(cfg_blk_len), PORTION_BYTES);

  // side selection by direction
  logic              prod_req, cons_req, prod_step, cons_step;
  logic              prod_full, cons_full, prod_done, cons_done;
  logic              prod_half, cons_half;
  logic [ADDR_W-1:0] prod_addr, cons_addr;
  logic [DATA_W-1:0] wr_word, rd_word;
  logic [NUM_PORTIONS-1:0] full_q;
  logic              ren, wen, bad_evt, rrdy_evt, wrdy_evt;

  assign prod_req  = cfg_dir_rd ? card_wr_valid : host_wr_valid;
  assign cons_req  = cfg_dir_rd ? host_rd_req   : card_rd_req;
  assign wr_word   = cfg_dir_rd ? card_wr_data  : host_wr_data;
  assign prod_full = full_q[prod_half];
  assign cons_full = full_q[cons_half];
  assign prod_step = prod_req && !prod_full;
  assign cons_step = cons_req && cons_full;

  cpb_walker #(.PORTION_WORDS(PORTION_WORDS), .ADDR_W(ADDR_W)) prod_walk_i (
    .clk(clk), .rst_n(rst_n), .step(prod_step), .single(single_mode),
    .last_off(last_off), .half(prod_half), .done(prod_done), .addr(prod_addr)
  );

  cpb_walker #(.PORTION_WORDS(PORTION_WORDS), .ADDR_W(ADDR_W)) cons_walk_i (
    .clk(clk), .rst_n(rst_n), .step(cons_step), .single(single_mode),
    .last_off(last_off), .half(cons_half), .done(cons_done), .addr(cons_addr)
  );

  // one full flag per portion
  for (genvar p = 0; p < NUM_PORTIONS; p++) begin : g_portion
    logic full_r;
    logic fill_p, drain_p;
    assign fill_p  = prod_done && (prod_half == 1'(p));
    assign drain_p = cons_done && (cons_half == 1'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) full_r <= 1'b0;
      else        full_r <= (full_r || fill_p) && !drain_p;
    end
    assign full_q[p] = full_r;
  end

  cpb_ram #(.DATA_W(DATA_W), .DEPTH(TOTAL_WORDS), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .we(prod_step), .waddr(prod_addr), .wdata(wr_word),
    .raddr(cons_addr), .rdata(rd_word)
  );

  cpb_irq_stat irq_i (
    .clk(clk), .rst_n(rst_n), .dir_rd(cfg_dir_rd), .single(single_mode),
    .prod_full(prod_full), .cons_full(cons_full),
    .prod_req(prod_req), .cons_req(cons_req),
    .prod_done(prod_done), .cons_done(cons_done),
    .irq_clr(irq_clr), .irq_flags(irq_flags), .buf_status(buf_status),
    .ren(ren), .wen(wen), .bad_evt(bad_evt),
    .rrdy_evt(rrdy_evt), .wrdy_evt(wrdy_evt)
  );

  assign card_in_ready  = cfg_dir_rd && !prod_full;
  assign card_out_valid = !cfg_dir_rd && cons_full;
  assign host_rd_data   = ren ? rd_word : '0;
  assign card_rd_data   = card_out_valid ? rd_word : '0;

endmodule

// File: rtl/cpb_checker.sv
module cpb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_dir_rd,
  input logic        single,
  input logic        prod_req,
  input logic        cons_req,
  input logic        prod_step,
  input logic        cons_step,
  input logic        card_in_ready,
  input logic        card_out_valid,
  input logic [31:0] host_rd_data,
  input logic [31:0] irq_clr,
  input logic [31:0] irq_flags,
  input logic [31:0] buf_status
);

  // R5: a host read with read enable low yields zero
  a_r5_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_rd && !buf_status[11]) |-> (host_rd_data == 32'h0));

  // R7: simultaneous requests in single-portion mode raise bad access
  a_r7_bad_single: assert property (@(posedge clk) disable iff (!rst_n)
    (single && prod_req && cons_req) |=> irq_flags[29]);

  // R7: bad access only ever rises in single-portion mode
  a_r7_no_bad_pp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[29]) |-> $past(single));

  // R6: in single-portion mode only one side moves data per cycle
  a_r6_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> !(prod_step && cons_step));

  // R10: read and write enable levels never coexist
  a_r10_levels_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_status[11] && buf_status[10]));

  // R2: card side is never asked to both deliver and take
  a_r2_card_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_in_ready && card_out_valid));

  // R12: read-ready stays set until cleared
  a_r12_rrdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[5] && !irq_clr[5]) |=> irq_flags[5]);

endmodule

bind card_pingpong_buf cpb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_dir_rd(cfg_dir_rd), .single(single_mode),
  .prod_req(prod_req), .cons_req(cons_req),
  .prod_step(prod_step), .cons_step(cons_step),
  .card_in_ready(card_in_ready), .card_out_valid(card_out_valid),
  .host_rd_data(32'(host_rd_data)), .irq_clr(irq_clr),
  .irq_flags(irq_flags), .buf_status(buf_status)
);

// File: tb/card_pingpong_buf_tb_top.sv
module card_pingpong_buf_tb_top;

  localparam int PW = 8;
  localparam int DW = 32;
  localparam int LW = 11;
  localparam int TW = 2 * PW;
  localparam int HB = PW * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dir_rd = 1'b1;
  logic [LW-1:0] cfg_blk_len = '0;
  logic          host_wr_valid = 1'b0, host_rd_req = 1'b0;
  logic          card_wr_valid = 1'b0, card_rd_req = 1'b0;
  logic [DW-1:0] host_wr_data = '0, card_wr_data = '0;
  logic [DW-1:0] host_rd_data, card_rd_data;
  logic          card_in_ready, card_out_valid;
  logic [31:0]   irq_clr = '0;
  logic [31:0]   irq_flags, buf_status;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  card_pingpong_buf #(.DATA_W(DW), .PORTION_WORDS(PW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dir_rd(cfg_dir_rd), .cfg_blk_len(cfg_blk_len),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_rd_req(host_rd_req), .host_rd_data(host_rd_data),
    .card_wr_valid(card_wr_valid), .card_wr_data(card_wr_data),
    .card_in_ready(card_in_ready), .card_rd_req(card_rd_req),
    .card_rd_data(card_rd_data), .card_out_valid(card_out_valid),
    .irq_clr(irq_clr), .irq_flags(irq_flags), .buf_status(buf_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (dir=%0d len=%0d)", req, act, exp, cfg_dir_rd, cfg_blk_len);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int words_of(int len);
    int w;
    w = len / 4 + ((len % 4) != 0 ? 1 : 0);
    if (w < 1) w = 1;
    if (w > TW) w = TW;
    return w;
  endfunction

  function automatic logic [31:0] pat(int blk, int idx, int len);
    return 32'hC0DE_0000 ^ 32'(blk * 32'h0101_0000) ^ 32'(len << 8) ^ 32'(idx);
  endfunction

  function automatic logic prod_rdy(bit dir);
    return dir ? card_in_ready : buf_status[10];
  endfunction

  function automatic logic cons_rdy(bit dir);
    return dir ? buf_status[11] : card_out_valid;
  endfunction

  task automatic idle();
    host_wr_valid = 1'b0; host_rd_req = 1'b0;
    card_wr_valid = 1'b0; card_rd_req = 1'b0;
    irq_clr = '0;
  endtask

  task automatic prod(input bit dir, input logic [31:0] d);
    if (dir) begin card_wr_valid = 1'b1; card_wr_data = d; end
    else     begin host_wr_valid = 1'b1; host_wr_data = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic cons(input bit dir, output logic [31:0] d);
    if (dir) host_rd_req = 1'b1; else card_rd_req = 1'b1;
    #1;
    d = dir ? host_rd_data : card_rd_data;
    @(negedge clk);
    idle();
  endtask

  task automatic clear_all();
    irq_clr = '1;
    @(negedge clk);
    idle();
  endtask

  task automatic run_case(input bit dir, input int len);
    int          w;
    bit          single;
    logic [31:0] d;
    w = words_of(len);
    single = (len > HB);
    cfg_dir_rd = dir;
    cfg_blk_len = LW'(len);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    eq("R1 irq at reset", irq_flags, 32'h0);
    eq("R1 status at reset", buf_status, dir ? 32'h0 : 32'h400);
    eq("R1 card_in_ready at reset", 32'(card_in_ready), 32'(dir));
    eq("R1 card_out_valid at reset", 32'(card_out_valid), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    if (!dir) eq("R9 write ready after reset", 32'(irq_flags[4]), 32'h1);
    clear_all();
    eq("R12 flags cleared", irq_flags, 32'h0);

    // R2: strobes of the inactive sides
    for (int i = 0; i < w; i++) begin
      if (dir) begin host_wr_valid = 1'b1; card_rd_req = 1'b1; end
      else     begin card_wr_valid = 1'b1; host_rd_req = 1'b1; end
      @(negedge clk);
      idle();
    end
    eq("R2 consumer idle after ignored strobes", 32'(cons_rdy(dir)), 32'h0);
    eq("R2 producer free after ignored strobes", 32'(prod_rdy(dir)), 32'h1);

    // block 0, last word held back
    for (int i = 0; i < w - 1; i++) prod(dir, pat(0, i, len));
    eq("R5 not readable before last word", 32'(cons_rdy(dir)), 32'h0);
    cons(dir, d);
    eq("R5 early read returns zero", d, 32'h0);
    prod(dir, pat(0, w - 1, len));
    @(negedge clk);
    eq("R10 consumer level after block", 32'(cons_rdy(dir)), 32'h1);
    if (dir) eq("R8 read ready after block", 32'(irq_flags[5]), 32'h1);
    else     eq("R9 write ready after block", 32'(irq_flags[4]), 32'(!single));
    if (single) eq("R6 producer blocked", 32'(prod_rdy(dir)), 32'h0);
    else        eq("R4 producer free for second portion", 32'(prod_rdy(dir)), 32'h1);

    if (!single) begin
      for (int i = 0; i < w; i++) prod(dir, pat(1, i, len));
      @(negedge clk);
      eq("R4 producer blocked after two blocks", 32'(prod_rdy(dir)), 32'h0);
    end
    clear_all();

    for (int i = 0; i < w; i++) begin
      cons(dir, d);
      eq("R3 block 0 word", d, pat(0, i, len));
    end
    @(negedge clk);
    if (!single) begin
      eq("R4 second portion readable", 32'(cons_rdy(dir)), 32'h1);
      if (dir) eq("R8 back-to-back read ready", 32'(irq_flags[5]), 32'h1);
      else     eq("R9 freed portion write ready", 32'(irq_flags[4]), 32'h1);
      for (int i = 0; i < w; i++) begin
        cons(dir, d);
        eq("R3 block 1 word", d, pat(1, i, len));
      end
      @(negedge clk);
    end else begin
      eq("R6 producer free after drain", 32'(prod_rdy(dir)), 32'h1);
      if (!dir) eq("R9 write ready after drain", 32'(irq_flags[4]), 32'h1);
    end
    eq("R10 consumer level empty", 32'(cons_rdy(dir)), 32'h0);

    // read when empty, then prove position did not move
    cons(dir, d);
    eq("R5 empty read returns zero", d, 32'h0);
    for (int i = 0; i < w; i++) prod(dir, pat(2, i, len));
    cons(dir, d);
    eq("R5 no advance on empty read", d, pat(2, 0, len));

    // simultaneous requests from both sides
    if (dir) begin card_wr_valid = 1'b1; host_rd_req = 1'b1; end
    else     begin host_wr_valid = 1'b1; card_rd_req = 1'b1; end
    card_wr_data = 32'h0; host_wr_data = 32'h0;
    @(negedge clk);
    idle();
    eq("R7 bad access flag", 32'(irq_flags[29]), 32'(single));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: every length from 0 past the capped store size, both directions
    for (int len = 0; len <= 2 * TW * 4 + 6; len++) begin
      run_case(1'b1, len);
      run_case(1'b0, len);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule